// File: doc/BRIEF.md
# Program Address Breakpoint Unit

This block gives an on-chip debug engine four hardware breakpoints on program memory addresses. Each breakpoint is a 16-bit register. A monitor-enable control bit turns address comparison on or off. A debug host reaches these registers only through background-mode commands, so user code can neither see nor change them.

While the CPU runs user code and the monitor is enabled, every valid instruction fetch address is compared against all four registers. On a match the unit raises a one-clock break request in the cycle after the fetch. The same edge reports which breakpoint fired, and the lowest index wins when several match at once. No comparison is made while the CPU is already in debug mode, so a breakpoint cannot fire again while the debug engine has control.

Top module: `prog_bkpt_unit`

## Requirements
- R1: After reset, all four breakpoint registers hold 0xFFFF, the monitor enable is 0, and the break request and the matched index are 0.
- R2: A write strobe with the background qualifier high, with the control select low, loads the selected breakpoint register (index 0 to 3 on `cmd_idx`) from `cmd_wdata`. A write with the background qualifier low changes no register.
- R3: Read data is valid on the clock after a read strobe that has the background qualifier high. In every other cycle, including the cycle after a read with the qualifier low, `cmd_rdata` is 0.
- R4: With the control select high, a background write sets the monitor enable from bit 0 of `cmd_wdata`. A background read of the control register returns the enable in bit 0 and zeros in bits 15 to 1.
- R5: While the monitor enable is 0, no fetch address raises a break request.
- R6: When `fetch_vld` is high, the monitor enable is 1, `in_debug` is low and `fetch_addr` equals any breakpoint register, `brk_req` is high for exactly the next clock cycle.
- R7: A fetch address presented with `fetch_vld` low never raises a break request.
- R8: A fetch presented while `in_debug` is high never raises a break request.
- R9: `brk_idx` changes together with each break request to the lowest index that matched. It holds its value in cycles without a break.
- R10: Comparison uses the register contents from before a write made in the same cycle. The new value takes effect for fetches from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_bg | input | 1 | Access comes from a background-mode debug command |
| cmd_ctl | input | 1 | Selects the control register instead of a breakpoint |
| cmd_idx | input | 2 | Breakpoint register index |
| cmd_wr | input | 1 | Write strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wdata | input | 16 | Write data |
| cmd_rdata | output | 16 | Read data, valid one clock after the read strobe |
| fetch_addr | input | 16 | Program address bus |
| fetch_vld | input | 1 | Instruction fetch valid strobe |
| in_debug | input | 1 | CPU is in debug mode |
| brk_req | output | 1 | Break request pulse |
| brk_idx | output | 2 | Index of the breakpoint behind the latest break |

## Verification
Every result of this block lands exactly one clock after the stimulus that causes it: read data after the read strobe, and the break pulse with its index after the matching fetch. A new register value only affects fetches from the next cycle on. The bench therefore drives each cycle's inputs on the falling edge and advances its reference model at the following rising edge. It then compares read data, break request and index at the next falling edge, every cycle. The same-cycle write-and-fetch case fixes the R10 ordering explicitly.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    localparam int BP_COUNT   = 4;
    localparam int BP_ADDR_W  = 16;
    localparam int CTL_EN_BIT = 0;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_BP   = 2'd1,
        ACC_CTL  = 2'd2
    } acc_kind_t;

    function automatic acc_kind_t acc_kind(input logic bg, input logic ctl);
        if (!bg)
            return ACC_NONE;
        return ctl ? ACC_CTL : ACC_BP;
    endfunction

endpackage

// File: rtl/bpu_regfile.sv
module bpu_regfile #(
    parameter int NUM_BP = bpu_pkg::BP_COUNT,
    parameter int ADDR_W = bpu_pkg::BP_ADDR_W,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_bg,
    input  logic                     cmd_ctl,
    input  logic [IDX_W-1:0]         cmd_idx,
    input  logic                     cmd_wr,
    input  logic                     cmd_rd,
    input  logic [ADDR_W-1:0]        cmd_wdata,
    output logic [ADDR_W-1:0]        cmd_rdata,
    output logic [NUM_BP*ADDR_W-1:0] bp_flat,
    output logic                     mon_en
);
    import bpu_pkg::*;

    acc_kind_t         kind;
    logic [ADDR_W-1:0] bp_q [NUM_BP];
    logic [ADDR_W-1:0] ctl_view;

    assign kind = acc_kind(cmd_bg, cmd_ctl);

    generate
        for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
            always_ff @(posedge clk) begin
                if (rst)
                    bp_q[g] <= '1;
                else if (kind == ACC_BP && cmd_wr && cmd_idx == IDX_W'(g))
                    bp_q[g] <= cmd_wdata;
            end
            assign bp_flat[g*ADDR_W +: ADDR_W] = bp_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            mon_en <= 1'b0;
        else if (kind == ACC_CTL && cmd_wr)
            mon_en <= cmd_wdata[CTL_EN_BIT];
    end

    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_EN_BIT] = mon_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmd_rdata <= '0;
        else if (cmd_rd && kind == ACC_BP)
            cmd_rdata <= bp_q[cmd_idx];
        else if (cmd_rd && kind == ACC_CTL)
            cmd_rdata <= ctl_view;
        else
            cmd_rdata <= '0;
    end

endmodule

// File: rtl/bpu_compare.sv
module bpu_compare #(
    parameter int NUM_BP = bpu_pkg::BP_COUNT,
    parameter int ADDR_W = bpu_pkg::BP_ADDR_W
) (
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic [NUM_BP*ADDR_W-1:0] bp_flat,
    output logic [NUM_BP-1:0]        hit_vec
);
    generate
        for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
            assign hit_vec[g] = (bp_flat[g*ADDR_W +: ADDR_W] == fetch_addr);
        end
    endgenerate
endmodule

// File: rtl/bpu_break_gen.sv
module bpu_break_gen #(
    parameter int NUM_BP = bpu_pkg::BP_COUNT,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_BP-1:0] hit_vec,
    input  logic              fetch_vld,
    input  logic              mon_en,
    input  logic              in_debug,
    output logic              brk_req,
    output logic [IDX_W-1:0]  brk_idx
);
    logic             armed;
    logic             any_hit;
    logic [IDX_W-1:0] first_idx;

    assign armed   = fetch_vld && mon_en && !in_debug;
    assign any_hit = |hit_vec;

    always_comb begin
        first_idx = '0;
        for (int i = NUM_BP - 1; i >= 0; i--) begin
            if (hit_vec[i])
                first_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_req <= 1'b0;
            brk_idx <= '0;
        end else begin
            brk_req <= armed && any_hit;
            if (armed && any_hit)
                brk_idx <= first_idx;
        end
    end
endmodule

// File: rtl/prog_bkpt_unit.sv
module prog_bkpt_unit #(
    parameter int NUM_BP = bpu_pkg::BP_COUNT,
    parameter int ADDR_W = bpu_pkg::BP_ADDR_W,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_bg,
    input  logic              cmd_ctl,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_wdata,
    output logic [ADDR_W-1:0] cmd_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_vld,
    input  logic              in_debug,
    output logic              brk_req,
    output logic [IDX_W-1:0]  brk_idx
);
    logic [NUM_BP*ADDR_W-1:0] bp_flat_w;
    logic                     mon_en_w;
    logic [NUM_BP-1:0]        hit_w;

    bpu_regfile #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_bg    (cmd_bg),
        .cmd_ctl   (cmd_ctl),
        .cmd_idx   (cmd_idx),
        .cmd_wr    (cmd_wr),
        .cmd_rd    (cmd_rd),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .bp_flat   (bp_flat_w),
        .mon_en    (mon_en_w)
    );

    bpu_compare #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_cmp (
        .fetch_addr (fetch_addr),
        .bp_flat    (bp_flat_w),
        .hit_vec    (hit_w)
    );

    bpu_break_gen #(.NUM_BP(NUM_BP)) u_brk (
        .clk       (clk),
        .rst       (rst),
        .hit_vec   (hit_w),
        .fetch_vld (fetch_vld),
        .mon_en    (mon_en_w),
        .in_debug  (in_debug),
        .brk_req   (brk_req),
        .brk_idx   (brk_idx)
    );
endmodule

// File: rtl/prog_bkpt_unit_chk.sv
module prog_bkpt_unit_chk #(
    parameter int NUM_BP = bpu_pkg::BP_COUNT,
    parameter int ADDR_W = bpu_pkg::BP_ADDR_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_bg,
    input logic                     cmd_wr,
    input logic                     cmd_rd,
    input logic [ADDR_W-1:0]        cmd_rdata,
    input logic                     fetch_vld,
    input logic                     in_debug,
    input logic                     brk_req,
    input logic                     mon_en,
    input logic [NUM_BP*ADDR_W-1:0] bp_flat
);
    // R1: state straight after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (bp_flat == '1) && !mon_en && !brk_req);

    // R2: foreground writes leave all state alone
    assert_fg_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_bg) |=> $stable(bp_flat) && $stable(mon_en));

    // R3: read data is zero unless a background read preceded
    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_rd && cmd_bg) |-> cmd_rdata == '0);

    // R5: a break needs the monitor enabled one cycle earlier
    assert_break_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(mon_en));

    // R7: a break needs a valid fetch one cycle earlier
    assert_break_needs_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(fetch_vld));

    // R8: no break from a fetch made in debug mode
    assert_no_break_in_debug_R8: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> !$past(in_debug));
endmodule

bind prog_bkpt_unit prog_bkpt_unit_chk #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_bg    (cmd_bg),
    .cmd_wr    (cmd_wr),
    .cmd_rd    (cmd_rd),
    .cmd_rdata (cmd_rdata),
    .fetch_vld (fetch_vld),
    .in_debug  (in_debug),
    .brk_req   (brk_req),
    .mon_en    (mon_en_w),
    .bp_flat   (bp_flat_w)
);

// File: tb/test_prog_bkpt_unit.sv
module test_prog_bkpt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_bg = 1'b0, cmd_ctl = 1'b0, cmd_wr = 1'b0, cmd_rd = 1'b0;
    logic [1:0]  cmd_idx = '0;
    logic [15:0] cmd_wdata = '0, fetch_addr = '0;
    logic        fetch_vld = 1'b0, in_debug = 1'b0;
    logic [15:0] cmd_rdata;
    logic        brk_req;
    logic [1:0]  brk_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // reference model state
    int unsigned m_bp [4];
    bit          m_en;
    int unsigned m_rdata;
    bit          m_brk;
    int unsigned m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_bkpt_unit i_prog_bkpt_unit (
        .clk(clk), .rst(rst), .cmd_bg(cmd_bg), .cmd_ctl(cmd_ctl), .cmd_idx(cmd_idx),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .fetch_addr(fetch_addr), .fetch_vld(fetch_vld), .in_debug(in_debug),
        .brk_req(brk_req), .brk_idx(brk_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // apply one cycle of stimulus, advance the model at the edge, compare after it
    task automatic step(input string tag, input bit bg, input bit ctl, input int idx,
                        input bit wr, input bit rd, input int unsigned wd,
                        input int unsigned fa, input bit fv, input bit dbg);
        int unsigned nxt_rd;
        bit          hit;
        int          first;
        cmd_bg = bg; cmd_ctl = ctl; cmd_idx = 2'(idx); cmd_wr = wr; cmd_rd = rd;
        cmd_wdata = 16'(wd); fetch_addr = 16'(fa); fetch_vld = fv; in_debug = dbg;
        @(posedge clk);
        nxt_rd = 0;
        if (rd && bg) nxt_rd = ctl ? int'(m_en) : m_bp[idx];
        hit = 0; first = 0;
        for (int k = 3; k >= 0; k--) begin
            if (m_bp[k] == (fa & 16'hFFFF)) begin hit = 1; first = k; end
        end
        m_rdata = nxt_rd;
        m_brk   = fv && m_en && !dbg && hit;
        if (m_brk) m_idx = first;
        if (wr && bg) begin
            if (ctl) m_en = wd[0];
            else     m_bp[idx] = wd & 16'hFFFF;
        end
        @(negedge clk);
        check(tag, "cmd_rdata", cmd_rdata, m_rdata);
        check(tag, "brk_req",   brk_req,   m_brk);
        check(tag, "brk_idx",   brk_idx,   m_idx);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int unsigned lfsr;
        for (int k = 0; k < 4; k++) m_bp[k] = 16'hFFFF;
        m_en = 0; m_rdata = 0; m_brk = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state through outputs and background reads
        idle("R1");
        for (int k = 0; k < 4; k++) begin
            step("R1", 1, 0, k, 0, 1, 0, 0, 0, 0);
            check("R1", "reset value", cmd_rdata, 16'hFFFF);
        end
        // R4: control reads zero after reset
        step("R4", 1, 1, 0, 0, 1, 0, 0, 0, 0);
        // R3: foreground read returns nothing
        step("R3", 0, 0, 2, 0, 1, 0, 0, 0, 0);
        check("R3", "foreground read", cmd_rdata, 0);
        idle("R3");
        // R5: monitor off, fetch to reset address
        step("R5", 0, 0, 0, 0, 0, 0, 16'hFFFF, 1, 0);
        // R2: background loads and an ignored foreground write
        step("R2", 1, 0, 0, 1, 0, 16'h0100, 0, 0, 0);
        step("R2", 1, 0, 1, 1, 0, 16'h0200, 0, 0, 0);
        step("R2", 1, 0, 2, 1, 0, 16'h0200, 0, 0, 0);
        step("R2", 1, 0, 3, 1, 0, 16'h0300, 0, 0, 0);
        step("R2", 0, 0, 0, 1, 0, 16'h1234, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R2", "bp0 after foreground write", cmd_rdata, 16'h0100);
        // R4: enable the monitor, read it back
        step("R4", 1, 1, 0, 1, 0, 16'hFFFF, 0, 0, 0);
        step("R4", 1, 1, 0, 0, 1, 0, 0, 0, 0);
        check("R4", "control read", cmd_rdata, 1);
        // R6 R9: match on 1 and 2 -> index 1, one-cycle pulse, index holds
        step("R9", 0, 0, 0, 0, 0, 0, 16'h0200, 1, 0);
        check("R6", "pulse", brk_req, 1);
        check("R9", "lowest index", brk_idx, 1);
        step("R6", 0, 0, 0, 0, 0, 0, 16'h0204, 1, 0);
        check("R6", "pulse ends", brk_req, 0);
        // R7: no strobe
        step("R7", 0, 0, 0, 0, 0, 0, 16'h0300, 0, 0);
        // R8: in debug
        step("R8", 0, 0, 0, 0, 0, 0, 16'h0300, 1, 1);
        step("R6", 0, 0, 0, 0, 0, 0, 16'h0300, 1, 0);
        check("R9", "index 3", brk_idx, 3);
        // R10: write with fetch of the old value in the same cycle
        step("R10", 1, 0, 3, 1, 0, 16'h0400, 16'h0300, 1, 0);
        check("R10", "old value matched", brk_req, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 16'h0300, 1, 0);
        check("R10", "old value gone", brk_req, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 16'h0400, 1, 0);
        // R2: foreground write of the control bit is ignored
        step("R2", 0, 1, 0, 1, 0, 0, 0, 0, 0);
        step("R2", 1, 1, 0, 0, 1, 0, 0, 0, 0);
        // R5: disable, matching fetch
        step("R5", 1, 1, 0, 1, 0, 0, 16'h0100, 1, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 16'h0100, 1, 0);
        // R6: mixed traffic with the monitor on
        step("R6", 1, 1, 0, 1, 0, 1, 0, 0, 0);
        lfsr = 32'h1ACE;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R6", lfsr[9], lfsr[10], int'(lfsr[12:11]), lfsr[13] & lfsr[14], lfsr[15],
                 {8'h0, 4'h0, lfsr[3:2], 2'b00} + 16'h0100 * (int'(lfsr[5:4]) + 1),
                 {12'h0, lfsr[19:18], 2'b00} + 16'h0100 * (int'(lfsr[17:16]) + 1),
                 lfsr[6], lfsr[7] & lfsr[8]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule